// File: doc/BRIEF.md
# Decode-Stage Interlock Unit

This block decides, every cycle, whether the instruction waiting in decode may advance in a five-stage in-order integer pipeline. The five stages are fetch, decode, execute, memory and write-back. The pipeline has no operand forwarding, so an instruction can read a register only after the older instruction that writes it has left write-back. Until then, the only safe action is to wait.

The unit compares each source register of the decode instruction with the destination register of the instructions in execute, memory and write-back. A source takes part only when its use flag is set. An immediate form sets only the first flag. A store sets both flags, because it reads its base register and its data register. A load writes the register named in its second source field, and the decoder supplies that number as the load's destination.

When a conflict exists, the unit raises a hold signal that freezes the PC and the fetch/decode register. It also raises a bubble signal that loads a no-op with write-enable cleared into the decode/execute register. A 2-bit code reports which stage caused the conflict.

The unit is purely combinational. Its outputs follow its inputs within the same cycle.

Top module: `hz_interlock`

## Requirements
- R1: When no enabled source matches any stage's destination, hold_fetch is 0, inject_nop is 0 and hz_kind is 0.
- R2: An enabled source equal to the execute-stage destination, with that stage writing, gives hz_kind = 1 (2'b01) and hold_fetch = 1.
- R3: An enabled source equal to the memory-stage destination, with that stage writing and execute not conflicting, gives hz_kind = 2 (2'b10) and hold_fetch = 1.
- R4: An enabled source equal to the write-back-stage destination, with that stage writing and neither younger stage conflicting, gives hz_kind = 3 (2'b11) and hold_fetch = 1.
- R5: A destination of register 0 never produces a conflict, whatever the sources are.
- R6: A stage whose write-enable is 0 never produces a conflict.
- R7: The first source is compared only when src_a_use is 1, and the second source is compared only when src_b_use is 1. A store sets both flags, so both of its sources are checked.
- R8: When several stages conflict, hz_kind names the youngest of them. Execute wins over memory, and memory wins over write-back.
- R9: inject_nop equals hold_fetch in every cycle, so a bubble is inserted exactly when the front of the pipe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | First source register of the decode instruction |
| src_a_use | input | 1 | First source is read |
| src_b | input | 5 | Second source register of the decode instruction |
| src_b_use | input | 1 | Second source is read |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination register of the write-back-stage instruction |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| hold_fetch | output | 1 | Freeze the PC and the fetch/decode register |
| inject_nop | output | 1 | Load a no-op with write-enable cleared into decode/execute |
| hz_kind | output | 2 | 0 none, 1 execute, 2 memory, 3 write-back |

## Verification
Every result is due in the same cycle as the stimulus that causes it, because no register lies between the ports. The bench therefore applies each input pattern on the rising clock edge and samples the outputs on the following falling edge, half a period later. Expected outputs come from a bench function that recomputes the priority comparison from the requirements. Directed patterns cover register 0, disabled write-enables, disabled sources, stores and multi-stage conflicts. Seeded random patterns fill in the remaining cases.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_AW = 5;
    localparam int N_STAGES = 3;

    typedef enum logic [1:0] {
        HZ_NONE = 2'd0,
        HZ_EX   = 2'd1,
        HZ_MEM  = 2'd2,
        HZ_WB   = 2'd3
    } hz_kind_e;
endpackage

// File: rtl/hz_stage_cmp.sv
module hz_stage_cmp #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_a,
    input  logic          src_a_use,
    input  logic [AW-1:0] src_b,
    input  logic          src_b_use,
    input  logic [AW-1:0] dst,
    input  logic          wr,
    output logic          hit
);
    logic live;

    always_comb begin
        live = wr && (dst != '0);
        hit  = live && ((src_a_use && (src_a == dst)) ||
                        (src_b_use && (src_b == dst)));
    end
endmodule

// File: rtl/hz_prio.sv
module hz_prio
    import hz_pkg::*;
#(
    parameter int N = N_STAGES
) (
    input  logic [N-1:0] hits,
    output hz_kind_e     kind
);
    always_comb begin
        unique casez (hits)
            3'b??1:  kind = HZ_EX;
            3'b?10:  kind = HZ_MEM;
            3'b100:  kind = HZ_WB;
            default: kind = HZ_NONE;
        endcase
    end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
(
    input  logic [REG_AW-1:0] src_a,
    input  logic              src_a_use,
    input  logic [REG_AW-1:0] src_b,
    input  logic              src_b_use,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_wr,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wr,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wr,
    output logic              hold_fetch,
    output logic              inject_nop,
    output logic [1:0]        hz_kind
);
    logic [REG_AW-1:0] stg_dst [N_STAGES];
    logic [N_STAGES-1:0] stg_wr;
    logic [N_STAGES-1:0] stg_hit;
    hz_kind_e kind;

    always_comb begin
        stg_dst[0] = ex_dst;
        stg_dst[1] = mem_dst;
        stg_dst[2] = wb_dst;
        stg_wr     = {wb_wr, mem_wr, ex_wr};
    end

    for (genvar g = 0; g < N_STAGES; g++) begin : g_cmp
        hz_stage_cmp #(.AW(REG_AW)) i_cmp (
            .src_a     (src_a),
            .src_a_use (src_a_use),
            .src_b     (src_b),
            .src_b_use (src_b_use),
            .dst       (stg_dst[g]),
            .wr        (stg_wr[g]),
            .hit       (stg_hit[g])
        );
    end

    hz_prio #(.N(N_STAGES)) i_prio (
        .hits (stg_hit),
        .kind (kind)
    );

    always_comb begin
        hold_fetch = |stg_hit;
        inject_nop = (kind != HZ_NONE);
        hz_kind    = kind;
    end
endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk (
    input logic [4:0] src_a,
    input logic       src_a_use,
    input logic [4:0] src_b,
    input logic       src_b_use,
    input logic [4:0] ex_dst,
    input logic       ex_wr,
    input logic [4:0] mem_dst,
    input logic       mem_wr,
    input logic [4:0] wb_dst,
    input logic       wb_wr,
    input logic       hold_fetch,
    input logic       inject_nop,
    input logic [1:0] hz_kind
);
    always_comb begin
        a_r9_nop_with_hold: assert (inject_nop == hold_fetch)
            else $error("R9 bubble and hold disagree");
        a_r1_kind_vs_hold: assert ((hz_kind != 2'd0) == hold_fetch)
            else $error("R1 code and hold disagree");
        a_r8_ex_first: assert (!(ex_wr && ex_dst != 5'd0 &&
                ((src_a_use && src_a == ex_dst) || (src_b_use && src_b == ex_dst)))
                || hz_kind == 2'd1)
            else $error("R8 execute conflict not reported first");
        a_r5_zero_quiet: assert (!(ex_dst == 5'd0 && mem_dst == 5'd0 && wb_dst == 5'd0)
                || !hold_fetch)
            else $error("R5 register 0 caused a hold");
        a_r6_no_writers: assert ((ex_wr || mem_wr || wb_wr) || !hold_fetch)
            else $error("R6 hold without any writer");
        a_r7_no_sources: assert ((src_a_use || src_b_use) || !hold_fetch)
            else $error("R7 hold without any source in use");
    end
endmodule

bind hz_interlock hz_interlock_chk i_chk (
    .src_a(src_a), .src_a_use(src_a_use), .src_b(src_b), .src_b_use(src_b_use),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .hold_fetch(hold_fetch),
    .inject_nop(inject_nop), .hz_kind(hz_kind)
);

// File: tb/test_hz_interlock.sv
module test_hz_interlock;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0] src_a, src_b, ex_dst, mem_dst, wb_dst;
    logic src_a_use, src_b_use, ex_wr, mem_wr, wb_wr;
    logic hold_fetch, inject_nop;
    logic [1:0] hz_kind;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hz_interlock i_hz_interlock (
        .src_a(src_a), .src_a_use(src_a_use), .src_b(src_b), .src_b_use(src_b_use),
        .ex_dst(ex_dst), .ex_wr(ex_wr), .mem_dst(mem_dst), .mem_wr(mem_wr),
        .wb_dst(wb_dst), .wb_wr(wb_wr), .hold_fetch(hold_fetch),
        .inject_nop(inject_nop), .hz_kind(hz_kind)
    );

    function automatic bit hits(input logic [4:0] d, input logic w);
        if (!w || d == 5'd0) return 1'b0;
        return (src_a_use && src_a == d) || (src_b_use && src_b == d);
    endfunction

    function automatic logic [1:0] exp_kind();
        if (hits(ex_dst, ex_wr))   return 2'd1;
        if (hits(mem_dst, mem_wr)) return 2'd2;
        if (hits(wb_dst, wb_wr))   return 2'd3;
        return 2'd0;
    endfunction

    task automatic apply(input logic [4:0] a, input logic au, input logic [4:0] b,
                         input logic bu, input logic [4:0] e, input logic ew,
                         input logic [4:0] m, input logic mw,
                         input logic [4:0] w, input logic ww, input string req);
        logic [1:0] k;
        @(posedge clk);
        src_a = a; src_a_use = au; src_b = b; src_b_use = bu;
        ex_dst = e; ex_wr = ew; mem_dst = m; mem_wr = mw; wb_dst = w; wb_wr = ww;
        @(negedge clk);
        k = exp_kind();
        checks++;
        if (hz_kind !== k || hold_fetch !== (k != 2'd0)) begin
            errors++;
            $display("FAIL %s: kind=%0d hold=%0b expected kind=%0d hold=%0b",
                     req, hz_kind, hold_fetch, k, (k != 2'd0));
        end
        checks++;
        if (inject_nop !== hold_fetch) begin
            errors++;
            $display("FAIL R9: nop=%0b expected %0b", inject_nop, hold_fetch);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
        apply(1, 1, 2, 1, 3, 1, 4, 1, 5, 1, "R1 no match");
        apply(7, 1, 0, 0, 7, 1, 9, 1, 9, 1, "R2 ex match");
        apply(4, 1, 8, 1, 1, 1, 8, 1, 2, 1, "R3 mem match");
        apply(6, 1, 11, 1, 1, 1, 2, 1, 11, 1, "R4 wb match");
        apply(0, 1, 0, 1, 0, 1, 0, 1, 0, 1, "R5 reg zero");
        apply(3, 1, 3, 1, 3, 0, 3, 0, 3, 0, "R6 no write");
        apply(1, 0, 9, 1, 1, 1, 1, 1, 1, 1, "R7 rs disabled");
        apply(1, 1, 9, 0, 9, 1, 9, 1, 9, 1, "R7 rt disabled");
        apply(2, 1, 12, 1, 12, 1, 0, 0, 0, 0, "R7 store data reg");
        apply(5, 1, 5, 1, 5, 1, 5, 1, 5, 1, "R8 all stages");
        apply(5, 1, 6, 1, 7, 1, 6, 1, 5, 1, "R8 mem over wb");
        apply(5, 1, 6, 1, 5, 0, 6, 0, 5, 1, "R8 wb after disabled");
        for (int i = 0; i < 2000; i++) begin
            apply($urandom % 8, $urandom % 2, $urandom % 8, $urandom % 2,
                  $urandom % 8, $urandom % 2, $urandom % 8, $urandom % 2,
                  $urandom % 8, $urandom % 2, "R8 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule